// File: doc/BRIEF.md
# Registered Output Macrocell Bank

This block is the output stage of a small programmable logic device. It holds a bank of identical output cells. Each cell receives one sum-of-products term from the logic array, which is outside this block. Three static configuration bits per cell set its behaviour. The first bit either sends the term through a storage flip-flop or passes it straight to the output. The second bit picks the clock edge on which that flip-flop captures. The third bit complements the value that reaches the pad.

Each cell has its own asynchronous preset and clear inputs, and clear takes priority. One clock and one output-enable input are shared by every cell. Each pad is modelled as a data bit plus an enable bit. The uncomplemented internal value of each cell goes back to the array as a feedback bit.

The configuration bits are meant to stay fixed while the device runs. They are loaded while reset is held and then left alone.

Top module: `mc_bank`

## Requirements
- R1: When `cfg_reg_i[i]` is 0 (bypass mode), `fb_o[i]` equals `sop_i[i]` at once, with no clock edge needed.
- R2: When `cfg_reg_i[i]` is 1 and `cfg_fall_i[i]` is 0, the cell's flip-flop stores `sop_i[i]` on each rising edge of `clk_i`, and `fb_o[i]` shows the stored value.
- R3: When `cfg_reg_i[i]` is 1 and `cfg_fall_i[i]` is 1, the flip-flop stores `sop_i[i]` only on falling edges of `clk_i`. A rising edge leaves it unchanged.
- R4: `pad_o[i]` equals `fb_o[i]` XOR `cfg_inv_i[i]`. The feedback bit is never complemented.
- R5: A high `clear_i[i]` forces the registered value of cell i to 0 at once, with no clock edge needed. The value stays 0 across clock edges while `clear_i[i]` is held.
- R6: A high `preset_i[i]`, with `clear_i[i]` low, forces the registered value of cell i to 1 at once. The value stays 1 across clock edges while `preset_i[i]` is held.
- R7: When `preset_i[i]` and `clear_i[i]` are both high, the registered value is 0.
- R8: Every bit of `pad_en_o` equals the shared `oe_i`. A low `oe_i` leaves `fb_o` unchanged.
- R9: While `rst_ni` is low, every flip-flop is 0 and clock edges have no effect on it. Cells in bypass mode still follow their sum-of-products input.
- R10: The preset and clear inputs of one cell have no effect on any other cell.
- R11: In bypass mode, `preset_i[i]` and `clear_i[i]` have no effect on `fb_o[i]` or `pad_o[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by all cells |
| rst_ni | input | 1 | Active-low asynchronous reset; clears every flip-flop |
| oe_i | input | 1 | Shared output enable for all pads |
| sop_i | input | CELLS | Sum-of-products term for each cell |
| preset_i | input | CELLS | Asynchronous set, one bit per cell |
| clear_i | input | CELLS | Asynchronous reset, one bit per cell; beats preset |
| cfg_reg_i | input | CELLS | 1 = registered output, 0 = combinational bypass |
| cfg_fall_i | input | CELLS | 1 = capture on the falling edge, 0 = capture on the rising edge |
| cfg_inv_i | input | CELLS | 1 = complement the pad value |
| pad_o | output | CELLS | Pad data value |
| pad_en_o | output | CELLS | Pad drive enable; 0 means high impedance |
| fb_o | output | CELLS | Internal value fed back to the array |

## Verification
On every rising clock edge the assertions check the following for each cell:
- bypass cells track their input;
- the pad polarity matches the invert bit;
- clear beats preset;
- a held preset reads 1.

Rising-edge capture is checked against the value sampled one edge earlier. Falling-edge capture gets its own check, clocked on the falling edge.

Some behaviours show up only in the bench's scenarios:
- the immediate effect of preset and clear between clock edges;
- a falling-edge cell holding its value through a rising edge;
- a pulse on one cell's clear leaving its neighbours alone;
- the flip-flops ignoring clock edges while reset is held.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef struct packed {
    logic reg_en;
    logic fall_edge;
    logic invert;
  } cell_cfg_t;

  localparam int unsigned CFG_BITS = $bits(cell_cfg_t);
endpackage

// File: rtl/mc_edge_dff.sv
module mc_edge_dff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  // polarity select folded into the clock path; fall_i is static config
  logic cap_clk;
  assign cap_clk = clk_i ^ fall_i;

  always_ff @(posedge cap_clk or negedge rst_ni or posedge clr_i or posedge set_i) begin
    if (!rst_ni)     q_o <= RST_VAL;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else             q_o <= d_i;
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      oe_i,
  input  cell_cfg_t cfg_i,
  input  logic      sop_i,
  input  logic      preset_i,
  input  logic      clear_i,
  output logic      pad_o,
  output logic      pad_en_o,
  output logic      fb_o
);
  logic q;
  logic sel;

  mc_edge_dff #(.RST_VAL(1'b0)) u_dff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (cfg_i.fall_edge),
    .set_i  (preset_i),
    .clr_i  (clear_i),
    .d_i    (sop_i),
    .q_o    (q)
  );

  always_comb begin
    sel = cfg_i.reg_en ? q : sop_i;
  end

  // feedback taken before the output complement
  assign fb_o     = sel;
  assign pad_o    = sel ^ cfg_i.invert;
  assign pad_en_o = oe_i;
endmodule

// File: rtl/mc_bank.sv
module mc_bank
  import mc_pkg::*;
#(
  parameter int unsigned CELLS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             oe_i,
  input  logic [CELLS-1:0] sop_i,
  input  logic [CELLS-1:0] preset_i,
  input  logic [CELLS-1:0] clear_i,
  input  logic [CELLS-1:0] cfg_reg_i,
  input  logic [CELLS-1:0] cfg_fall_i,
  input  logic [CELLS-1:0] cfg_inv_i,
  output logic [CELLS-1:0] pad_o,
  output logic [CELLS-1:0] pad_en_o,
  output logic [CELLS-1:0] fb_o
);
  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    cell_cfg_t cfg;
    assign cfg = '{reg_en: cfg_reg_i[g], fall_edge: cfg_fall_i[g], invert: cfg_inv_i[g]};

    mc_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .oe_i     (oe_i),
      .cfg_i    (cfg),
      .sop_i    (sop_i[g]),
      .preset_i (preset_i[g]),
      .clear_i  (clear_i[g]),
      .pad_o    (pad_o[g]),
      .pad_en_o (pad_en_o[g]),
      .fb_o     (fb_o[g])
    );
  end
endmodule

// File: rtl/mc_bank_chk.sv
module mc_bank_chk #(
  parameter int unsigned CELLS = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             oe_i,
  input logic [CELLS-1:0] sop_i,
  input logic [CELLS-1:0] preset_i,
  input logic [CELLS-1:0] clear_i,
  input logic [CELLS-1:0] cfg_reg_i,
  input logic [CELLS-1:0] cfg_fall_i,
  input logic [CELLS-1:0] cfg_inv_i,
  input logic [CELLS-1:0] pad_o,
  input logic [CELLS-1:0] pad_en_o,
  input logic [CELLS-1:0] fb_o
);
  // set once an edge of each polarity has passed since reset release
  logic ok_p, ok_n;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ok_p <= 1'b0; else ok_p <= 1'b1;
  always_ff @(negedge clk_i or negedge rst_ni)
    if (!rst_ni) ok_n <= 1'b0; else ok_n <= 1'b1;

  for (genvar g = 0; g < CELLS; g++) begin : g_chk
    assert_bypass_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_reg_i[g] |-> fb_o[g] == sop_i[g]);

    assert_pad_polarity_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_o[g] == (fb_o[g] ^ cfg_inv_i[g]));

    assert_clear_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_reg_i[g] && clear_i[g]) |-> !fb_o[g]);

    assert_preset_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_reg_i[g] && preset_i[g] && !clear_i[g]) |-> fb_o[g]);

    assert_rise_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_p && cfg_reg_i[g] && !cfg_fall_i[g] && !clear_i[g] && !preset_i[g]
       && !$past(clear_i[g]) && !$past(preset_i[g]) && $stable(cfg_fall_i[g]))
      |-> fb_o[g] == $past(sop_i[g]));

    assert_fall_capture_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (ok_n && cfg_reg_i[g] && cfg_fall_i[g] && !clear_i[g] && !preset_i[g]
       && !$past(clear_i[g]) && !$past(preset_i[g]) && $stable(cfg_fall_i[g]))
      |-> fb_o[g] == $past(sop_i[g]));
  end

  logic unused;
  assign unused = ^{oe_i, pad_en_o};
endmodule

bind mc_bank mc_bank_chk #(.CELLS(CELLS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .oe_i       (oe_i),
  .sop_i      (sop_i),
  .preset_i   (preset_i),
  .clear_i    (clear_i),
  .cfg_reg_i  (cfg_reg_i),
  .cfg_fall_i (cfg_fall_i),
  .cfg_inv_i  (cfg_inv_i),
  .pad_o      (pad_o),
  .pad_en_o   (pad_en_o),
  .fb_o       (fb_o)
);

// File: tb/mc_bank_test.sv
module mc_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int CELLS = 4;
  // fields: sop[12:9] oe[8] exp_fb[7:4] exp_pad[3:0]
  // cfg: cell0 bypass, cell1 rise, cell2 fall, cell3 rise; invert on cells 1 and 3
  localparam logic [12:0] VEC [0:5] = '{
    {4'b1111, 1'b1, 4'b1011, 4'b0001},
    {4'b0000, 1'b0, 4'b0100, 4'b1110},
    {4'b0101, 1'b1, 4'b0001, 4'b1011},
    {4'b1010, 1'b1, 4'b1110, 4'b0100},
    {4'b0110, 1'b0, 4'b0010, 4'b1000},
    {4'b1001, 1'b1, 4'b1101, 4'b0111}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic oe;
  logic [CELLS-1:0] sop, preset, clear, cfg_reg, cfg_fall, cfg_inv;
  logic [CELLS-1:0] pad, pad_en, fb;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_bank #(.CELLS(CELLS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .oe_i(oe), .sop_i(sop),
    .preset_i(preset), .clear_i(clear), .cfg_reg_i(cfg_reg),
    .cfg_fall_i(cfg_fall), .cfg_inv_i(cfg_inv),
    .pad_o(pad), .pad_en_o(pad_en), .fb_o(fb)
  );

  task automatic chk(input string tag, input logic [CELLS-1:0] act, input logic [CELLS-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic half_step;  // to 2 units after the next falling edge
    @(negedge clk); #2;
  endtask

  initial begin
    rst_ni = 1'b0; oe = 1'b0; sop = 4'b1111; preset = '0; clear = '0;
    cfg_reg = 4'b1110; cfg_fall = 4'b0100; cfg_inv = 4'b1010;
    #3;
    chk("R9 reset fb", fb, 4'b0001);
    chk("R4 reset pad", pad, 4'b1011);
    chk("R8 reset pad_en", pad_en, 4'b0000);
    repeat (2) @(posedge clk);
    #2 chk("R9 edges ignored in reset", fb, 4'b0001);
    half_step; sop = '0; rst_ni = 1'b1;
    repeat (3) @(posedge clk);

    // table: R1 R2 R3 R4 R8
    for (int k = 0; k < 6; k++) begin
      half_step;
      sop = VEC[k][12:9]; oe = VEC[k][8];
      @(posedge clk); #2;
      chk($sformatf("R1/R2/R3 fb vec%0d", k), fb, VEC[k][7:4]);
      chk($sformatf("R4 pad vec%0d", k), pad, VEC[k][3:0]);
      chk($sformatf("R8 pad_en vec%0d", k), pad_en, {CELLS{VEC[k][8]}});
    end

    // fill all flops with 1
    half_step; sop = 4'b1111;
    half_step;
    chk("R2/R3 fill", fb, 4'b1111);

    // R5 clear, R11 bypass ignores it
    clear = 4'b1111; #1;
    chk("R5 R11 clear immediate", fb, 4'b0001);
    @(posedge clk); #2 chk("R5 clear held over edge", fb, 4'b0001);
    half_step; clear = '0; #1;
    chk("R5 holds after release", fb, 4'b0001);
    @(posedge clk); #2 chk("R2 recapture after clear", fb, 4'b1011);
    half_step;

    // R6 preset, R11
    sop = 4'b0000; preset = 4'b1111; #1;
    chk("R6 R11 preset immediate", fb, 4'b1110);
    @(posedge clk); #2 chk("R6 preset held over edge", fb, 4'b1110);
    half_step; preset = '0;
    @(posedge clk); #2 chk("R3 rise leaves fall cell", fb, 4'b0100);
    half_step; chk("R3 fall capture", fb, 4'b0000);

    // R7 both asserted
    sop = 4'b1111; preset = 4'b1111; clear = 4'b1111; #1;
    chk("R7 clear wins", fb, 4'b0001);
    @(posedge clk); #2 chk("R7 clear wins over edge", fb, 4'b0001);
    half_step; preset = '0; clear = '0;
    @(posedge clk); half_step;
    chk("R2 refill", fb, 4'b1111);

    // R10 one-cell clear
    clear = 4'b0010; #1;
    chk("R10 single-cell clear", fb, 4'b1101);
    @(posedge clk); #2 chk("R10 neighbours keep capturing", fb, 4'b1101);
    half_step; clear = '0;
    @(posedge clk); #2 chk("R10 cleared cell recaptures", fb, 4'b1111);
    half_step;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule